// File: doc/BRIEF.md
# Write-Only Two-Wire Clock-Control Slave

This block is a serial slave on a two-wire bus that accepts write transfers only. A bus master uses it to load a small bank of 8-bit control registers, and each bit of that bank turns one clock output of the chip on or off. The serial clock and serial data lines are brought in as plain inputs and sampled in a faster system clock domain. The block acknowledges by asserting an open-drain pull-down request on the data line.

There is no register pointer. After a start condition and the matching device address, the first data byte always lands in register 0, the next in register 1, and so on up to the last register. To change a register near the end of the bank, a master must resend every register in front of it. Any address other than the write address, a read request, or bytes past the end of the bank are left unanswered, and the registers keep their contents.

The system clock must run at least ten times faster than the serial bit rate. This lets the block tell start and stop conditions apart from ordinary data bits after synchronization.

Top module: `clkctl_wr_slave`

## Requirements
- R1: A falling data edge while the serial clock is high starts address reception. A rising data edge while the serial clock is high ends the transfer, and later clock pulses are ignored until the next start.
- R2: Bytes are shifted in most significant bit first on rising serial clock edges. Each byte is followed by one acknowledge bit slot.
- R3: An address byte equal to 0xD2 (write, bit 0 = 0) is acknowledged. The block holds the data line low for the whole high phase of that acknowledge slot.
- R4: Any other address byte, including the read address 0xD3, gets no acknowledge. The bytes that follow it are not acknowledged and change no register.
- R5: After a matching address, data byte k of the transfer (k counted from 0) is written to register k, which occupies bits 8k+7 down to 8k of `ctl_regs_o`. Each such byte is acknowledged.
- R6: At most NUM_REGS (default 10) data bytes are accepted per transfer. Any byte after that gets no acknowledge and changes no register.
- R7: A start that arrives in the middle of a byte drops the partial byte without writing it, and address reception begins again.
- R8: After reset every register reads 0xFF and the pull-down request is released.
- R9: Bit j of `out_en_o` equals bit j of `ctl_regs_o`, so a 1 enables clock output j.
- R10: The pull-down request is asserted only on a falling serial clock edge that opens an acknowledge slot. It is released on the falling edge that closes that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the serial bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| sda_pull_o | output | 1 | 1 = pull the data line low (acknowledge) |
| ctl_regs_o | output | NUM_REGS*8 | Control registers, register k at bits 8k+7:8k |
| out_en_o | output | NUM_OUTS | Per-output clock enable bits |

## Verification
A bit counter that slips by even one position moves the pull-down into a data bit or out of the acknowledge slot. This shows on the wired data line as a wrong acknowledge level within the same byte. A register index or mode that is wrong writes the wrong register, or writes a register when it should not. The per-clock comparison of `ctl_regs_o` and `out_en_o` catches this in the first low phase of the serial clock after the eighth bit. A missed start or stop leaves the mode stale, and the next byte then produces an acknowledge where none is expected, or none where one is.

// File: rtl/clkctl_wr_slave.sv
module clkctl_wr_slave #(
  parameter int          NUM_REGS = 10,
  parameter int          NUM_OUTS = 32,
  parameter logic [7:0]  DEV_ADDR = 8'hD2,
  parameter logic [7:0]  RST_VAL  = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pull_o,
  output logic [NUM_REGS*8-1:0]  ctl_regs_o,
  output logic [NUM_OUTS-1:0]    out_en_o
);

  localparam int IDX_W = $clog2(NUM_REGS + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_REGS);

  typedef enum logic [1:0] {M_IDLE, M_ADDR, M_DATA, M_SKIP} mode_t;

  logic [1:0]             scl_sy, sda_sy;
  logic                   scl_d, sda_d;
  mode_t                  mode;
  logic [3:0]             cnt;
  logic [6:0]             shreg;
  logic [IDX_W-1:0]       idx;
  logic                   ack_pend;
  logic [NUM_REGS-1:0][7:0] regs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_ev  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_ev   = scl_s & scl_d & ~sda_d & sda_s;
  wire [7:0] byte_nx = {shreg, sda_s};
  wire in_xfer   = (mode == M_ADDR) || (mode == M_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= M_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      idx        <= '0;
      ack_pend   <= 1'b0;
      sda_pull_o <= 1'b0;
      for (int k = 0; k < NUM_REGS; k++) regs[k] <= RST_VAL;
    end else if (start_ev) begin
      mode       <= M_ADDR;
      cnt        <= '0;
      idx        <= '0;
      ack_pend   <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (stop_ev) begin
      mode       <= M_IDLE;
      cnt        <= '0;
      ack_pend   <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (in_xfer) begin
      if (scl_rise && cnt < 4'd8) begin
        shreg <= byte_nx[6:0];
        cnt   <= cnt + 4'd1;
        if (cnt == 4'd7) begin
          if (mode == M_ADDR) begin
            if (byte_nx == DEV_ADDR) begin
              ack_pend <= 1'b1;
              mode     <= M_DATA;
            end else begin
              mode     <= M_SKIP;
            end
          end else if (idx < IDX_LAST) begin
            regs[idx] <= byte_nx;
            idx       <= idx + IDX_W'(1);
            ack_pend  <= 1'b1;
          end else begin
            mode <= M_SKIP;
          end
        end
      end else if (scl_fall && cnt == 4'd8) begin
        cnt        <= 4'd9;
        sda_pull_o <= ack_pend;
      end else if (scl_fall && cnt == 4'd9) begin
        cnt        <= '0;
        sda_pull_o <= 1'b0;
        ack_pend   <= 1'b0;
      end
    end
  end

  assign ctl_regs_o = regs;
  assign out_en_o   = regs[NUM_OUTS-1:0];

  assert_start_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!sda_pull_o && mode == M_ADDR && cnt == 4'd0));

  assert_pull_in_ack_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (cnt == 4'd9));

  assert_pull_rises_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(scl_fall));

  assert_quiet_when_ignoring_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SKIP || mode == M_IDLE) |=> $stable(regs));

  assert_write_on_eighth_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $past(scl_rise && cnt == 4'd7 && mode == M_DATA));

  assert_index_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_LAST);

endmodule

// File: tb/clkctl_wr_slave_bench.sv
module clkctl_wr_slave_bench;
  localparam int NR = 10;
  localparam int NO = 32;
  localparam int Q  = 4;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic pull;
  logic [NR*8-1:0] regs_o;
  logic [NO-1:0]   en_o;
  wire  sda_w = sda_m & ~pull;

  always #5 clk = ~clk;

  clkctl_wr_slave u_clkctl_wr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w),
    .sda_pull_o(pull), .ctl_regs_o(regs_o), .out_en_o(en_o));

  int nchk = 0;
  int nfail = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  logic [NR*8-1:0] exp_regs;
  int m_phase = 0;
  int m_idx = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      if (nfail < 20) $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (cmp_en && !done) begin
      chk(regs_o == exp_regs, "R5 register bank", 128'(regs_o), 128'(exp_regs));
      chk(en_o == exp_regs[NO-1:0], "R9 enable vector", 128'(en_o), 128'(exp_regs[NO-1:0]));
    end
  end

  task automatic model_byte(input logic [7:0] b, output bit ack, output string tag);
    ack = 1'b0;
    tag = "R4";
    if (m_phase == 1) begin
      if (b == 8'hD2) begin ack = 1'b1; m_phase = 2; tag = "R3"; end
      else m_phase = 3;
    end else if (m_phase == 2) begin
      if (m_idx < NR) begin
        exp_regs[m_idx*8 +: 8] = b;
        m_idx++;
        ack = 1'b1;
        tag = "R5";
      end else begin
        m_phase = 3;
        tag = "R6";
      end
    end
  endtask

  task automatic do_start();
    if (!scl_m) begin sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); end
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(Q);
    m_phase = 1; m_idx = 0;
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(H);
    m_phase = 0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit ack_e;
    string tag;
    ack_e = 1'b0;
    tag = "R2";
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      cmp_en = 1'b0; scl_m = 1'b1; tick(H);
      scl_m = 1'b0;
      if (i == 0) model_byte(b, ack_e, tag);
      cmp_en = 1'b1; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    cmp_en = 1'b0; scl_m = 1'b1; tick(Q);
    chk(sda_w == !ack_e, {tag, " R2 ack slot level"}, 128'(sda_w), 128'(!ack_e));
    tick(Q);
    scl_m = 1'b0; cmp_en = 1'b1; tick(Q);
  endtask

  initial begin
    exp_regs = '1;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    chk(regs_o == {NR{8'hFF}}, "R8 reset registers", 128'(regs_o), 128'({NR{8'hFF}}));
    chk(pull == 1'b0, "R8 reset pull released", 128'(pull), 128'(0));
    cmp_en = 1'b1;

    // R3 R5 R2: short write, MSB-first patterns
    do_start(); send_byte(8'hD2); send_byte(8'h81); send_byte(8'h3C); send_byte(8'h00); do_stop();
    tick(H);
    chk(regs_o[7:0] == 8'h81, "R2 MSB first reg0", 128'(regs_o[7:0]), 128'(8'h81));
    chk(en_o[23:16] == 8'h00, "R9 outputs disabled", 128'(en_o[23:16]), 128'(0));

    // R5 R6: full bank plus two extra bytes
    do_start(); send_byte(8'hD2);
    for (int k = 0; k < NR; k++) send_byte(8'(8'h10 + 8'(k) * 8'h11));
    send_byte(8'hEE); send_byte(8'h55); do_stop();
    tick(H);
    chk(regs_o[NR*8-1 -: 8] == 8'(8'h10 + 8'(NR-1) * 8'h11), "R6 last register kept",
        128'(regs_o[NR*8-1 -: 8]), 128'(8'(8'h10 + 8'(NR-1) * 8'h11)));

    // R4: wrong address and read address
    do_start(); send_byte(8'hA4); send_byte(8'h00); send_byte(8'h00); do_stop();
    do_start(); send_byte(8'hD3); send_byte(8'h00); do_stop();
    tick(H);
    chk(pull == 1'b0, "R4 no pull after ignored transfers", 128'(pull), 128'(0));

    // R1: clock pulses after stop without a start are ignored
    m_phase = 3;
    send_byte(8'hD2); send_byte(8'h00);
    do_stop();

    // R7: start inside a data byte drops the partial byte
    do_start(); send_byte(8'hD2); send_byte(8'h5A);
    send_bits(8'h00, 4);
    do_start(); send_byte(8'hD2); send_byte(8'hC3); send_byte(8'h99); do_stop();
    tick(H);
    chk(regs_o[15:0] == 16'h99C3, "R7 restart rewrites from reg0", 128'(regs_o[15:0]), 128'(16'h99C3));

    // R1: repeated start without stop, then a single byte
    do_start(); send_byte(8'hD2); send_byte(8'h11);
    do_start(); send_byte(8'hD2); send_byte(8'h22); do_stop();
    tick(H);
    chk(regs_o[7:0] == 8'h22, "R1 repeated start", 128'(regs_o[7:0]), 128'(8'h22));

    tick(H);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule